// File: doc/BRIEF.md
# Nested Multilevel Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. Every maskable line is assigned one of three priority levels (low, medium, high) through a two-bit code, and a separate non-maskable request line ranks above all of them. Each cycle the controller picks the single request the core should take next. It issues a one-cycle acknowledge pulse that carries the vector number and level of that request, and it records the level as executing.

Executing flags nest. A flag stays set while its handler is pre-empted by a higher level, so the set of raised flags always describes the stack of handlers in progress. A request is taken only if its level ranks above every level that is already executing. A return-from-interrupt pulse from the core pops the innermost handler. For the low level, software can turn on round-robin arbitration. In that mode a byte-wide register keeps the vector most recently acknowledged at low level, and that vector goes to the back of the queue in the next low-level arbitration. Software reads the status and this register over a small register port, and it can also write the register.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the status register (address 0) and the last-vector register (address 1) both read 0x00, and `ack` is low.
- R2: Between levels, non-maskable ranks first, then high (code 2), then medium (code 1), then low (code 0). A line with level code 3 is never acknowledged. A level whose `lvl_en` bit is clear (bit 0 low, bit 1 medium, bit 2 high) is never acknowledged.
- R3: Within one level, the lowest line index wins. This always applies to medium and high, and applies to low whenever `rr_en` is 0.
- R4: A request held at a clock edge where it wins produces `ack` high for exactly the following cycle. `ack_vec` gives the line index (or `NMI_VEC` for the non-maskable request), `ack_lvl` gives the level code (3 for non-maskable), and the flag of that level is set.
- R5: A maskable request is taken only if its level ranks above every level whose executing flag is set. The non-maskable request is taken unless a non-maskable handler is already executing.
- R6: In the status byte, bit 7 is the non-maskable executing flag, bit 2 is high, bit 1 is medium and bit 0 is low. A flag stays set while its handler is pre-empted by higher levels.
- R7: A `reti` pulse clears only the highest-ranked flag that is set.
- R8: Status bits 6 to 3 always read zero, and a write to address 0 changes no status bit.
- R9: The last-vector register at address 1 reads back the value written to it.
- R10: When `rr_en` is 1, each low-level acknowledge stores its vector in the last-vector register. The next low-level pick then goes to the lowest pending index above the stored value, and wraps to the lowest pending index when there is none above it. When `rr_en` is 0, acknowledges leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ | Maskable request lines, level-sensitive |
| irq_lvl | input | 2*N_IRQ | Level code per line, bits [2i+1:2i] for line i |
| nmi_req | input | 1 | Non-maskable request |
| lvl_en | input | 3 | Per-level enables: bit 0 low, bit 1 medium, bit 2 high |
| rr_en | input | 1 | Round-robin enable for the low level |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| ack | output | 1 | One-cycle acknowledge |
| ack_vec | output | 8 | Acknowledged vector number |
| ack_lvl | output | 2 | Acknowledged level code |
| reg_addr | input | 1 | Register select: 0 status, 1 last-vector |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
The bench uses four lines. It runs through every one of the 256 level-code assignments with all lines requesting, which separates the ordering between levels, the lowest-index rule and the exclusion of code 3. A sweep over all eight enable combinations with a fixed line-to-level mapping isolates the masking. Round-robin is run for every stored last value against every non-empty low-level mask, which exposes the rotation and the wraparound. A fixed stack of low, medium, high and non-maskable handlers, with blocked requests inserted and then unwound one `reti` at a time, tells nesting, pre-emption retention and innermost-only clearing apart.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_MED = 2'd1,
        LVL_HI  = 2'd2,
        LVL_NMI = 2'd3
    } lvl_e;

    typedef struct packed {
        logic       nmi;
        logic [2:0] lvl;
    } exec_t;
endpackage

// File: rtl/nic_lvl_arb.sv
module nic_lvl_arb
    import nic_pkg::*;
#(
    parameter int N          = 8,
    parameter bit RR_CAPABLE = 1'b0
) (
    input  logic [N-1:0]     pend,
    input  logic             rr_on,
    input  logic [VEC_W-1:0] last,
    output logic             valid,
    output logic [VEC_W-1:0] idx
);
    logic [N-1:0] sel;

    generate
        if (RR_CAPABLE) begin : g_rr
            logic [N-1:0] above;
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    above[i] = pend[i] && (VEC_W'(i) > last);
                end
                sel = (rr_on && (|above)) ? above : pend;
            end
        end else begin : g_fixed
            logic unused_rr;
            assign unused_rr = rr_on ^ (|last);
            assign sel = pend;
        end
    endgenerate

    always_comb begin
        valid = |sel;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) idx = VEC_W'(i);
        end
    end
endmodule

// File: rtl/nic_nest_pop.sv
module nic_nest_pop
    import nic_pkg::*;
(
    input  exec_t cur,
    output exec_t popped
);
    always_comb begin
        popped = cur;
        if (cur.nmi)         popped.nmi    = 1'b0;
        else if (cur.lvl[2]) popped.lvl[2] = 1'b0;
        else if (cur.lvl[1]) popped.lvl[1] = 1'b0;
        else if (cur.lvl[0]) popped.lvl[0] = 1'b0;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int               N_IRQ   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [2*N_IRQ-1:0] irq_lvl,
    input  logic               nmi_req,
    input  logic [2:0]         lvl_en,
    input  logic               rr_en,
    input  logic               reti,
    output logic               ack,
    output logic [VEC_W-1:0]   ack_vec,
    output logic [1:0]         ack_lvl,
    input  logic               reg_addr,
    input  logic               reg_wr,
    input  logic [VEC_W-1:0]   reg_wdata,
    output logic [VEC_W-1:0]   reg_rdata
);
    typedef struct packed {
        exec_t            ex;
        logic [VEC_W-1:0] pri;
        logic             ack;
        logic [VEC_W-1:0] vec;
        lvl_e             lvl;
    } st_t;

    st_t st_d, st_q;

    logic [2:0][N_IRQ-1:0] pend;
    logic [2:0]            arb_v;
    logic [VEC_W-1:0]      arb_idx [3];
    logic [2:0]            elig;
    exec_t                 ex_pop;

    always_comb begin
        for (int l = 0; l < 3; l++) begin
            for (int i = 0; i < N_IRQ; i++) begin
                pend[l][i] = irq_req[i] && (irq_lvl[2*i +: 2] == 2'(l));
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < 3; g++) begin : g_arb
            nic_lvl_arb #(
                .N          (N_IRQ),
                .RR_CAPABLE (g == 0)
            ) u_arb (
                .pend  (pend[g]),
                .rr_on (rr_en),
                .last  (st_q.pri),
                .valid (arb_v[g]),
                .idx   (arb_idx[g])
            );
        end
    endgenerate

    nic_nest_pop u_pop (
        .cur    (st_q.ex),
        .popped (ex_pop)
    );

    always_comb begin
        elig[2] = lvl_en[2] && !st_q.ex.nmi && !st_q.ex.lvl[2];
        elig[1] = lvl_en[1] && !st_q.ex.nmi && !(|st_q.ex.lvl[2:1]);
        elig[0] = lvl_en[0] && !st_q.ex.nmi && !(|st_q.ex.lvl);
    end

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;

        if (reti) st_d.ex = ex_pop;

        if (reg_wr && reg_addr) st_d.pri = reg_wdata;

        if (nmi_req && !st_q.ex.nmi) begin
            st_d.ack    = 1'b1;
            st_d.vec    = NMI_VEC;
            st_d.lvl    = LVL_NMI;
            st_d.ex.nmi = 1'b1;
        end else if (elig[2] && arb_v[2]) begin
            st_d.ack       = 1'b1;
            st_d.vec       = arb_idx[2];
            st_d.lvl       = LVL_HI;
            st_d.ex.lvl[2] = 1'b1;
        end else if (elig[1] && arb_v[1]) begin
            st_d.ack       = 1'b1;
            st_d.vec       = arb_idx[1];
            st_d.lvl       = LVL_MED;
            st_d.ex.lvl[1] = 1'b1;
        end else if (elig[0] && arb_v[0]) begin
            st_d.ack       = 1'b1;
            st_d.vec       = arb_idx[0];
            st_d.lvl       = LVL_LO;
            st_d.ex.lvl[0] = 1'b1;
            if (rr_en) st_d.pri = arb_idx[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ex: '0, pri: '0, ack: 1'b0, vec: '0, lvl: LVL_LO};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack       = st_q.ack;
    assign ack_vec   = st_q.vec;
    assign ack_lvl   = st_q.lvl;
    assign reg_rdata = reg_addr ? st_q.pri : {st_q.ex.nmi, 4'b0000, st_q.ex.lvl};
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk
    import nic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic [VEC_W-1:0] ack_vec,
    input logic [1:0]       ack_lvl,
    input logic             reti,
    input logic             rr_en,
    input logic             reg_addr,
    input logic [VEC_W-1:0] reg_rdata,
    input logic             ex_nmi,
    input logic [2:0]       ex_lvl,
    input logic [VEC_W-1:0] pri
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[6:3] == 4'b0000)); // R8

    AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((ack_lvl == 2'd3) ? ex_nmi : ex_lvl[ack_lvl])); // R4

    AST_ACK_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_lvl != 2'd3) |-> (!$past(ex_nmi) && (($past(ex_lvl) >> ack_lvl) == 3'b000))); // R5

    AST_NMI_NOT_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_lvl == 2'd3) |-> !$past(ex_nmi)); // R5

    AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && (ex_nmi || (|ex_lvl))) |=>
            (ack || ($countones({ex_nmi, ex_lvl}) + 1 == $countones($past({ex_nmi, ex_lvl}))))); // R7

    AST_RR_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_lvl == 2'd0 && $past(rr_en)) |-> (pri == ack_vec)); // R10
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .ack_vec   (ack_vec),
    .ack_lvl   (ack_lvl),
    .reti      (reti),
    .rr_en     (rr_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ex_nmi    (st_q.ex.nmi),
    .ex_lvl    (st_q.ex.lvl),
    .pri       (st_q.pri)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    localparam int N = 4;
    localparam logic [7:0] NMIV = 8'hFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [2*N-1:0] irq_lvl = '0;
    logic         nmi_req = 1'b0;
    logic [2:0]   lvl_en = 3'b111;
    logic         rr_en = 1'b0;
    logic         reti = 1'b0;
    logic         ack;
    logic [7:0]   ack_vec;
    logic [1:0]   ack_lvl;
    logic         reg_addr = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_wdata = '0;
    logic [7:0]   reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.N_IRQ(N), .NMI_VEC(NMIV)) dut_i (
        .clk, .rst_n, .irq_req, .irq_lvl, .nmi_req, .lvl_en, .rr_en, .reti,
        .ack, .ack_vec, .ack_lvl, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input bit a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input bit a, input logic [7:0] v);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Present a request set for one edge; returns what the core sees afterwards.
    task automatic present(input logic [N-1:0] rq, input logic [2*N-1:0] lv, input bit nmi,
                           output bit a, output logic [7:0] v, output logic [1:0] l);
        irq_req = rq; irq_lvl = lv; nmi_req = nmi;
        @(negedge clk);
        a = ack; v = ack_vec; l = ack_lvl;
        irq_req = '0; nmi_req = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic check_quiet(input string req);
        @(negedge clk);
        chk(ack == 1'b0, req, ack, 0);
    endtask

    initial begin
        bit a;
        logic [7:0] v, s;
        logic [1:0] l;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, s); chk(s == 8'h00, "R1 status", s, 0);
        rd(1'b1, s); chk(s == 8'h00, "R1 lastvec", s, 0);
        chk(ack == 1'b0, "R1 ack", ack, 0);

        // R9 register read/write
        wr(1'b1, 8'hA5);
        rd(1'b1, s); chk(s == 8'hA5, "R9 readback", s, 8'hA5);
        wr(1'b1, 8'h00);

        // R8 status write ignored
        wr(1'b0, 8'hFF);
        rd(1'b0, s); chk(s == 8'h00, "R8 write to status", s, 0);

        // R2 R3 R4: every level-code assignment, all lines requesting
        for (int c = 0; c < 256; c++) begin
            int best, win;
            best = -1; win = -1;
            for (int i = 0; i < N; i++) begin
                int code;
                code = (c >> (2*i)) & 3;
                if (code < 3 && code > best) begin best = code; win = i; end
            end
            present('1, 8'(c), 1'b0, a, v, l);
            if (best < 0) begin
                chk(a == 1'b0, "R2 code3 never acked", a, 0);
            end else begin
                chk(a && v == 8'(win) && l == 2'(best), "R3 winner",
                    {a, v, 6'(0), l}, {1'b1, 8'(win), 6'(0), 2'(best)});
                rd(1'b0, s); chk(s == 8'(1 << best), "R4 flag set", s, 1 << best);
                check_quiet("R4 single pulse");
                do_reti();
            end
        end

        // R2 level enables: line0 low, line1 med, line2 high, line3 low
        for (int e = 0; e < 8; e++) begin
            int best, win;
            lvl_en = 3'(e);
            best = -1; win = -1;
            for (int i = 0; i < N; i++) begin
                if (e[i % 3] && (i % 3) > best) begin best = i % 3; win = i; end
            end
            present('1, 8'b00_10_01_00, 1'b0, a, v, l);
            if (best < 0) chk(a == 1'b0, "R2 all disabled", a, 0);
            else begin
                chk(a && v == 8'(win), "R2 enable mask", v, win);
                do_reti();
            end
        end
        lvl_en = 3'b111;

        // R10 round-robin sweep on low level
        rr_en = 1'b1;
        for (int last = 0; last < N; last++) begin
            for (int m = 1; m < 16; m++) begin
                int win;
                win = -1;
                for (int i = N - 1; i > last; i--) if (m[i]) win = i;
                if (win < 0) for (int i = N - 1; i >= 0; i--) if (m[i]) win = i;
                wr(1'b1, 8'(last));
                present(4'(m), '0, 1'b0, a, v, l);
                chk(a && v == 8'(win), "R10 rr pick", v, win);
                rd(1'b1, s); chk(s == 8'(win), "R10 rr record", s, win);
                do_reti();
            end
        end
        rr_en = 1'b0;
        wr(1'b1, 8'd2);
        present('1, '0, 1'b0, a, v, l);
        chk(a && v == 8'd0, "R10 rr off fixed pick", v, 0);
        rd(1'b1, s); chk(s == 8'd2, "R10 rr off no record", s, 2);
        do_reti();

        // R5 R6 R7 nesting stack
        present(4'b0001, 8'b00_00_00_00, 1'b0, a, v, l);
        rd(1'b0, s); chk(a && s == 8'h01, "R6 low running", s, 8'h01);
        present(4'b0010, 8'b00_00_01_00, 1'b0, a, v, l);
        rd(1'b0, s); chk(a && l == 2'd1 && s == 8'h03, "R6 med over low", s, 8'h03);
        present(4'b0001, 8'b00_00_00_00, 1'b0, a, v, l);
        chk(a == 1'b0, "R5 low blocked", a, 0);
        present(4'b0001, 8'b00_00_00_01, 1'b0, a, v, l);
        chk(a == 1'b0, "R5 equal level blocked", a, 0);
        present(4'b0100, 8'b00_10_00_00, 1'b0, a, v, l);
        rd(1'b0, s); chk(a && v == 8'd2 && s == 8'h07, "R6 high over med", s, 8'h07);
        present('0, '0, 1'b1, a, v, l);
        rd(1'b0, s); chk(a && v == NMIV && l == 2'd3 && s == 8'h87, "R6 nmi over high", s, 8'h87);
        present(4'b0100, 8'b00_10_00_00, 1'b1, a, v, l);
        chk(a == 1'b0, "R5 nmi and high blocked in nmi", a, 0);
        wr(1'b0, 8'h00);
        rd(1'b0, s); chk(s == 8'h87, "R8 status write with flags", s, 8'h87);
        do_reti(); rd(1'b0, s); chk(s == 8'h07, "R7 pop nmi", s, 8'h07);
        do_reti(); rd(1'b0, s); chk(s == 8'h03, "R7 pop high", s, 8'h03);
        present(4'b0100, 8'b00_10_00_00, 1'b0, a, v, l);
        rd(1'b0, s); chk(a && s == 8'h07, "R5 high after pop", s, 8'h07);
        do_reti(); do_reti(); rd(1'b0, s); chk(s == 8'h01, "R7 pop to low", s, 8'h01);
        do_reti(); rd(1'b0, s); chk(s == 8'h00, "R7 empty", s, 8'h00);
        do_reti(); rd(1'b0, s); chk(s == 8'h00, "R7 reti on empty", s, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule